// File: doc/BRIEF.md
# ModR/M Effective Address Generator

This block decodes the addressing byte that follows an opcode in a 16-bit x86-style processor. It reports whether the operand is a register or a memory location. For a memory operand it forms the address as a segment value paired with a 16-bit offset. The offset comes from the base and index registers that the mode selects. When the mode carries a displacement, the displacement is added to that sum.

Some modes need a displacement or a direct address. In those modes the block pulls one or two bytes from the instruction byte stream through a valid/ready handshake. It then adds them to the base sum and pulses `done`. The results stay on the outputs until the next accepted start.

The instruction decoder drives the byte and `start`, and supplies the current BX, BP, SI, DI, DS and SS values. It reads the result when `done` is high.

Top module: `modrmEaGen`

## Requirements
- R1: The byte on `modrm` is split into three fields: mode = bits 7:6, `regField` = bits 5:3, rm = bits 2:0. When `done` is high, `regField` shows bits 5:3 of the byte that was accepted.
- R2: In mode 11 the operand is a register. `done` is high in the cycle after start, `isReg` = 1 and `rmReg` = rm. `eaAddr` = 0 and no stream byte is accepted.
- R3: In mode 00 with rm other than 110, no stream byte is fetched. `done` is high in the cycle after start, and `eaAddr` holds the register sum given in R7.
- R4: In mode 00 with rm = 110 (direct), two bytes are fetched, low byte first. The offset is {second, first}, the segment is DS, and no register is added.
- R5: In mode 01, one byte is fetched, sign-extended to 16 bits, and added to the R7 sum.
- R6: In mode 10, two bytes are fetched as a 16-bit displacement, low byte first, and added to the R7 sum.
- R7: The rm field picks the base/index sum and the default segment. rm 0 = BX+SI with DS, rm 1 = BX+DI with DS, rm 2 = BP+SI with SS, rm 3 = BP+DI with SS, rm 4 = SI with DS, rm 5 = DI with DS, rm 6 = BP with SS, rm 7 = BX with DS. The register values are sampled in the start cycle.
- R8: All offset arithmetic is 16 bits wide and wraps modulo 65536.
- R9: `eaAddr` is 32 bits wide. It carries the segment in bits 31:16 and the offset in bits 15:0.
- R10: A stream byte is consumed only in a cycle where `byteValid` and `byteReady` are both high. `byteReady` is low whenever no fetch is pending, and stays high across cycles where `byteValid` is low.
- R11: `done` is high for exactly one cycle. For a memory mode that fetches bytes, that cycle is the one after the last byte is accepted.
- R12: A start that arrives while a fetch is pending is ignored. The decode in progress completes with its original byte and fields.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin decoding `modrm` |
| modrm | input | 8 | Addressing byte |
| regBx | input | 16 | Current BX |
| regBp | input | 16 | Current BP |
| regSi | input | 16 | Current SI |
| regDi | input | 16 | Current DI |
| segDs | input | 16 | Current DS |
| segSs | input | 16 | Current SS |
| byteValid | input | 1 | Stream byte offered |
| byteData | input | 8 | Stream byte |
| byteReady | output | 1 | Block will take a stream byte |
| done | output | 1 | Result available (one-cycle pulse) |
| isReg | output | 1 | Operand is a register |
| regField | output | 3 | Bits 5:3 of the decoded byte |
| rmReg | output | 3 | Bits 2:0 of the decoded byte |
| eaAddr | output | 32 | {segment, offset} |

## Verification
The hardest situation to reach from the ports is a second start that arrives while the block is stalled between displacement bytes. That start carries a different byte, and a stray valid byte on the stream must not be taken either before or after it.

The bench sweeps all 256 addressing bytes against several register sets, including sets that force the offset to wrap. It inserts gaps of zero, one or two cycles with valid low before each displacement byte. During those gaps it holds start high with an inverted byte. It also offers a junk byte with valid high in every start cycle. The results must still match sums computed from the first byte and the intended displacement.

// File: rtl/modrmEaPkg.sv
package modrmEaPkg;
  localparam int WordW  = 16;
  localparam int ByteW  = 8;
  localparam int FieldW = 3;

  typedef enum logic [1:0] {StIdle, StLo, StHi} eaState_e;

  typedef struct packed {
    logic load;        // latch byte, base sum and segment
    logic takeLo;      // store first of two stream bytes
    logic finishShort; // add sign-extended single byte
    logic finishLong;  // add {current byte, stored byte}
  } eaStrobe_t;

  // Number of stream bytes a given addressing byte requires.
  function automatic logic [1:0] dispCount(logic [ByteW-1:0] m);
    case (m[7:6])
      2'b00:   dispCount = (m[2:0] == 3'b110) ? 2'd2 : 2'd0;
      2'b01:   dispCount = 2'd1;
      2'b10:   dispCount = 2'd2;
      default: dispCount = 2'd0;
    endcase
  endfunction

  function automatic logic isDirect(logic [ByteW-1:0] m);
    isDirect = (m[7:6] == 2'b00) && (m[2:0] == 3'b110);
  endfunction
endpackage

// File: rtl/modrmEaDatapath.sv
module modrmEaDatapath
  import modrmEaPkg::*;
#(
  parameter int WORD_W  = WordW,
  parameter int BYTE_W  = ByteW,
  parameter int FIELD_W = FieldW
) (
  input  logic                clk,
  input  logic                rstN,
  input  eaStrobe_t           strobe,
  input  logic [BYTE_W-1:0]   modrm,
  input  logic [WORD_W-1:0]   regBx,
  input  logic [WORD_W-1:0]   regBp,
  input  logic [WORD_W-1:0]   regSi,
  input  logic [WORD_W-1:0]   regDi,
  input  logic [WORD_W-1:0]   segDs,
  input  logic [WORD_W-1:0]   segSs,
  input  logic [BYTE_W-1:0]   byteData,
  output logic                isReg,
  output logic [FIELD_W-1:0]  regField,
  output logic [FIELD_W-1:0]  rmReg,
  output logic [2*WORD_W-1:0] eaAddr
);
  localparam int ExtW = WORD_W - BYTE_W;

  logic [WORD_W-1:0]   baseNow, segNow, baseQ, segQ;
  logic [BYTE_W-1:0]   loQ;
  logic [2*WORD_W-1:0] addrQ;
  logic [FIELD_W-1:0]  regQ, rmQ;
  logic                isRegQ;
  logic [WORD_W-1:0]   shortDisp, longDisp;

  always_comb begin
    baseNow = '0;
    segNow  = segDs;
    case (modrm[2:0])
      3'd0: baseNow = regBx + regSi;
      3'd1: baseNow = regBx + regDi;
      3'd2: begin baseNow = regBp + regSi; segNow = segSs; end
      3'd3: begin baseNow = regBp + regDi; segNow = segSs; end
      3'd4: baseNow = regSi;
      3'd5: baseNow = regDi;
      3'd6: begin baseNow = regBp; segNow = segSs; end
      default: baseNow = regBx;
    endcase
    if (isDirect(modrm)) begin
      baseNow = '0;
      segNow  = segDs;
    end
  end

  assign shortDisp = {{ExtW{byteData[BYTE_W-1]}}, byteData};
  assign longDisp  = {byteData, loQ};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ  <= '0;
      segQ   <= '0;
      loQ    <= '0;
      addrQ  <= '0;
      regQ   <= '0;
      rmQ    <= '0;
      isRegQ <= 1'b0;
    end else begin
      if (strobe.load) begin
        regQ   <= modrm[5:3];
        rmQ    <= modrm[2:0];
        isRegQ <= (modrm[7:6] == 2'b11);
        baseQ  <= baseNow;
        segQ   <= segNow;
        if (modrm[7:6] == 2'b11)
          addrQ <= '0;
        else if (dispCount(modrm) == 2'd0)
          addrQ <= {segNow, baseNow};
      end
      if (strobe.takeLo)
        loQ <= byteData;
      if (strobe.finishShort)
        addrQ <= {segQ, baseQ + shortDisp};
      if (strobe.finishLong)
        addrQ <= {segQ, baseQ + longDisp};
    end
  end

  assign isReg    = isRegQ;
  assign regField = regQ;
  assign rmReg    = rmQ;
  assign eaAddr   = addrQ;
endmodule

// File: rtl/modrmEaControl.sv
module modrmEaControl
  import modrmEaPkg::*;
#(
  parameter int BYTE_W = ByteW
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [BYTE_W-1:0] modrm,
  input  logic              byteValid,
  output logic              byteReady,
  output logic              done,
  output eaStrobe_t         strobe
);
  eaState_e stateQ, stateD;
  logic     needTwoQ, needTwoD;
  logic     doneQ, doneD;
  logic     accept;

  assign byteReady = (stateQ != StIdle);
  assign accept    = byteReady && byteValid;

  always_comb begin
    stateD   = stateQ;
    needTwoD = needTwoQ;
    doneD    = 1'b0;
    strobe   = '0;
    case (stateQ)
      StIdle: if (start) begin
        strobe.load = 1'b1;
        case (dispCount(modrm))
          2'd0:    doneD = 1'b1;
          2'd1:    begin stateD = StLo; needTwoD = 1'b0; end
          default: begin stateD = StLo; needTwoD = 1'b1; end
        endcase
      end
      StLo: if (accept) begin
        if (needTwoQ) begin
          strobe.takeLo = 1'b1;
          stateD        = StHi;
        end else begin
          strobe.finishShort = 1'b1;
          doneD              = 1'b1;
          stateD             = StIdle;
        end
      end
      StHi: if (accept) begin
        strobe.finishLong = 1'b1;
        doneD             = 1'b1;
        stateD            = StIdle;
      end
      default: stateD = StIdle;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ   <= StIdle;
      needTwoQ <= 1'b0;
      doneQ    <= 1'b0;
    end else begin
      stateQ   <= stateD;
      needTwoQ <= needTwoD;
      doneQ    <= doneD;
    end
  end

  assign done = doneQ;
endmodule

// File: rtl/modrmEaGen.sv
module modrmEaGen
  import modrmEaPkg::*;
#(
  parameter int WORD_W  = WordW,
  parameter int BYTE_W  = ByteW,
  parameter int FIELD_W = FieldW
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                start,
  input  logic [BYTE_W-1:0]   modrm,
  input  logic [WORD_W-1:0]   regBx,
  input  logic [WORD_W-1:0]   regBp,
  input  logic [WORD_W-1:0]   regSi,
  input  logic [WORD_W-1:0]   regDi,
  input  logic [WORD_W-1:0]   segDs,
  input  logic [WORD_W-1:0]   segSs,
  input  logic                byteValid,
  input  logic [BYTE_W-1:0]   byteData,
  output logic                byteReady,
  output logic                done,
  output logic                isReg,
  output logic [FIELD_W-1:0]  regField,
  output logic [FIELD_W-1:0]  rmReg,
  output logic [2*WORD_W-1:0] eaAddr
);
  eaStrobe_t strobe;

  modrmEaControl #(.BYTE_W(BYTE_W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start), .modrm(modrm),
    .byteValid(byteValid), .byteReady(byteReady), .done(done),
    .strobe(strobe)
  );

  modrmEaDatapath #(.WORD_W(WORD_W), .BYTE_W(BYTE_W), .FIELD_W(FIELD_W)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .modrm(modrm),
    .regBx(regBx), .regBp(regBp), .regSi(regSi), .regDi(regDi),
    .segDs(segDs), .segSs(segSs), .byteData(byteData),
    .isReg(isReg), .regField(regField), .rmReg(rmReg), .eaAddr(eaAddr)
  );
endmodule

// File: rtl/modrmEaChecker.sv
module modrmEaChecker #(
  parameter int BYTE_W  = 8,
  parameter int FIELD_W = 3
) (
  input logic              clk,
  input logic              rstN,
  input logic              start,
  input logic [BYTE_W-1:0] modrm,
  input logic              byteValid,
  input logic              byteReady,
  input logic              done,
  input logic              isReg,
  input logic [FIELD_W-1:0] regField
);
  // R2: register mode completes next cycle without opening the stream
  a_r2_reg_mode: assert property (@(posedge clk) disable iff (!rstN)
    start && !byteReady && modrm[7:6] == 2'b11 |=> done && isReg && !byteReady);

  // R5, R6: displacement modes open the stream and do not finish yet
  a_r5_fetch_opens: assert property (@(posedge clk) disable iff (!rstN)
    start && !byteReady && (modrm[7:6] == 2'b01 || modrm[7:6] == 2'b10)
    |=> byteReady && !done);

  // R11: done follows either an accepted start or an accepted byte
  a_r11_done_cause: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(start && !byteReady) || $past(byteValid && byteReady));

  // R10: the stream is closed once the result is out
  a_r10_ready_low_done: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !byteReady);

  // R12: a start during a pending fetch leaves the decoded fields alone
  a_r12_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    byteReady && start |=> $stable(regField) && $stable(isReg));
endmodule

bind modrmEaGen modrmEaChecker #(.BYTE_W(BYTE_W), .FIELD_W(FIELD_W)) uChk (
  .clk(clk), .rstN(rstN), .start(start), .modrm(modrm),
  .byteValid(byteValid), .byteReady(byteReady), .done(done),
  .isReg(isReg), .regField(regField)
);

// File: tb/sim_modrmEaGen.sv
module sim_modrmEaGen;
  localparam int ClkPeriod = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [7:0]  modrm = '0;
  logic [15:0] regBx = '0, regBp = '0, regSi = '0, regDi = '0, segDs = '0, segSs = '0;
  logic        byteValid = 1'b0;
  logic [7:0]  byteData = '0;
  logic        byteReady, done, isReg;
  logic [2:0]  regField, rmReg;
  logic [31:0] eaAddr;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #(ClkPeriod/2) clk = ~clk;

  modrmEaGen u0 (
    .clk(clk), .rstN(rstN), .start(start), .modrm(modrm),
    .regBx(regBx), .regBp(regBp), .regSi(regSi), .regDi(regDi),
    .segDs(segDs), .segSs(segSs), .byteValid(byteValid), .byteData(byteData),
    .byteReady(byteReady), .done(done), .isReg(isReg),
    .regField(regField), .rmReg(rmReg), .eaAddr(eaAddr)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expectAddr(input logic [7:0] m, input logic [7:0] lo, input logic [7:0] hi);
    logic [15:0] base, seg, disp;
    seg = segDs;
    case (m[2:0])
      3'd0: base = regBx + regSi;
      3'd1: base = regBx + regDi;
      3'd2: begin base = regBp + regSi; seg = segSs; end
      3'd3: begin base = regBp + regDi; seg = segSs; end
      3'd4: base = regSi;
      3'd5: base = regDi;
      3'd6: begin base = regBp; seg = segSs; end
      default: base = regBx;
    endcase
    case (m[7:6])
      2'b00: disp = 16'd0;
      2'b01: disp = {{8{lo[7]}}, lo};
      default: disp = {hi, lo};
    endcase
    if (m[7:6] == 2'b11) return 32'd0;
    if (m[7:6] == 2'b00 && m[2:0] == 3'b110) return {segDs, hi, lo};
    return {seg, 16'(base + disp)};
  endfunction

  task automatic runOp(input logic [7:0] m, input logic [7:0] lo, input logic [7:0] hi, input int gap);
    int nb;
    logic [31:0] exp;
    nb = (m[7:6] == 2'b01) ? 1 :
         (m[7:6] == 2'b10 || (m[7:6] == 2'b00 && m[2:0] == 3'b110)) ? 2 : 0;
    exp = expectAddr(m, lo, hi);
    @(negedge clk);
    start = 1'b1; modrm = m;
    byteValid = 1'b1; byteData = ~lo;     // junk offered while idle (R10)
    @(negedge clk);
    start = 1'b0; byteValid = 1'b0;
    if (nb == 0) begin
      check("R2/R3 done after start", {31'd0, done}, 32'd1);
      check("R10 ready low no fetch", {31'd0, byteReady}, 32'd0);
      check("R2 isReg", {31'd0, isReg}, {31'd0, m[7:6] == 2'b11});
      check("R1 regField", {29'd0, regField}, {29'd0, m[5:3]});
      if (m[7:6] == 2'b11) check("R2 rmReg", {29'd0, rmReg}, {29'd0, m[2:0]});
      check("R3 R7 R9 address", eaAddr, exp);
    end else begin
      check("R5 R6 fetch opens", {30'd0, byteReady, done}, 32'd2);
      for (int b = 0; b < nb; b++) begin
        for (int g = 0; g < gap; g++) begin
          start = 1'b1; modrm = ~m;       // R12: start while fetch pending
          @(negedge clk);
          start = 1'b0;
          check("R10 ready held in stall", {30'd0, byteReady, done}, 32'd2);
        end
        byteValid = 1'b1;
        byteData  = (b == 0) ? lo : hi;
        @(negedge clk);
        byteValid = 1'b0;
        if (b < nb - 1)
          check("R11 no done mid fetch", {31'd0, done}, 32'd0);
      end
      check("R11 done after last byte", {30'd0, done, byteReady}, 32'd2);
      check("R12 R1 regField kept", {29'd0, regField}, {29'd0, m[5:3]});
      check("R4 R5 R6 R8 R9 address", eaAddr, exp);
      check("R2 isReg low", {31'd0, isReg}, 32'd0);
    end
    @(negedge clk);
    check("R11 done one cycle", {31'd0, done}, 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset ready", {31'd0, byteReady}, 32'd0);
    check("R11 reset done", {31'd0, done}, 32'd0);
    check("R9 reset addr", eaAddr, 32'd0);
    rstN = 1'b1;
    for (int set = 0; set < 3; set++) begin
      case (set)
        0: begin regBx = 16'h0010; regBp = 16'h0200; regSi = 16'h0003; regDi = 16'h0040;
                 segDs = 16'h1000; segSs = 16'h2000; end
        1: begin regBx = 16'hFFF0; regBp = 16'hFF80; regSi = 16'h0020; regDi = 16'h8001;
                 segDs = 16'hA5A5; segSs = 16'h5A5A; end
        default: begin regBx = 16'h1234; regBp = 16'h0000; regSi = 16'hFFFF; regDi = 16'h7FFF;
                 segDs = 16'h0F0F; segSs = 16'hF0F0; end
      endcase
      for (int m = 0; m < 256; m++)
        runOp(8'(m), 8'(m * 37 + set * 91), 8'(m ^ (8'hA5 + set)), (m + set) % 3);
    end
    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule